// File: doc/BRIEF.md
# Dual-Address Presence-Detect Memory and Thermal Sensor Serial Slave

This block is a slave on a two-wire serial bus (I2C / SMBus style) that answers on two device addresses at once. One address opens a 256-byte presence-detect memory. The lower half of that memory holds the module's identity and timing bytes, and the upper half is free for user data. The other address opens a small register set for a temperature sensor. That register set holds the latest 12-bit temperature code, a critical limit and an enable bit, and it drives an active-low alarm pin. SCL and SDA are sampled on the system clock and pass through a glitch filter before start, stop and bit edges are detected. The block pulls SDA low through an open-drain enable.

A bus master addresses the memory with a type nibble of 1010 and the sensor with 0011. Three strap pins complete both addresses. After a memory write the memory part goes busy for a self-timed write period and ignores its address. A write-protect input freezes the lower half of the memory. An SCL-low timeout returns the interface to idle, so a master that stalls cannot hold SDA low forever. An external converter model supplies temperature codes of 1/16 °C per LSB, each with a valid strobe.

Top module: `dual_id_i2c_slave`

## Requirements
- R1: An address byte with the top nibble 1010, the next three bits equal to strap_i[2:0] and bit 0 giving the direction (1 = read) is acknowledged when no write cycle is in progress. Any other type nibble, or strap bits that differ from strap_i, gets no acknowledge.
- R2: An address byte with the top nibble 0011, the next three bits equal to strap_i and bit 0 giving the direction is acknowledged at all times. A strap mismatch gets no acknowledge.
- R3: Every byte travels most significant bit first. In a memory write, the first byte after the address loads the byte pointer and later bytes are stored at the pointer. A memory read returns the byte at the pointer.
- R4: The memory pointer advances by one after each data byte, whether read or written, and wraps from 255 to 0. A repeated start leaves the pointer unchanged, so a pointer write followed by a repeated-start read reads from that pointer.
- R5: While wp_i is high, data bytes aimed at pointers 0 to 127 are acknowledged but leave the memory unchanged. Pointers 128 to 255 stay writable.
- R6: When a transaction that carried at least one memory data byte ends with a stop, the memory address gets no acknowledge for WBUSY_CYC clock cycles. The sensor address is still acknowledged in that period.
- R7: If SCL stays low for TOUT_CYC clock cycles while a transaction is open, the interface returns to idle and releases SDA, even in the middle of a read byte.
- R8: A level on SCL or SDA that lasts fewer than FILT_CYC clock cycles is ignored. A short low pulse on SDA while SCL is high is not taken as a start.
- R9: Sensor pointer 0 reads as the 16-bit value {4'b0000, code}. The high byte comes first. The code is refreshed on each cycle in which temp_vld_i is high. Writes to pointer 0 have no effect.
- R10: Sensor pointer 1 is the critical limit, held in the low 12 bits, with reset value CRIT_RST (default 1360, which is 85 °C). Sensor pointer 2 holds the alarm enable in bit 0, with reset value 1. A register write sends the pointer, then the high byte, then the low byte, and takes effect on the low byte. Reads return the high byte first.
- R11: evt_n_o is low exactly when the enable is set and the temperature code is greater than or equal to the limit. It follows a register change one clock later and is high out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire (wired-AND) |
| strap_i | input | 3 | Board strap bits completing both device addresses |
| wp_i | input | 1 | Write lock for memory bytes 0 to 127 |
| temp_smp_i | input | TEMP_W | Temperature code from the converter, 1/16 °C per LSB |
| temp_vld_i | input | 1 | Strobe that loads temp_smp_i |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA |
| evt_n_o | output | 1 | Active-low critical-temperature alarm |

## Verification
Two functions share a single decode point. The first is the end of the self-timed write period. The second is the address decision for the next transaction, taken on the falling clock edge after the eighth address bit. The bench provokes this by addressing the memory right after the stop that closes a write. It expects no acknowledge there and an acknowledge from the sensor address in the same window, and it expects the memory to answer again once the window has passed. A second overlap pairs the SCL-low timeout with a read bit the slave is driving low. The stalled line must be seen low first and released later.

// File: rtl/i2cdual_pkg.sv
package i2cdual_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } bus_st_e;

  localparam logic [3:0] MEM_TYPE = 4'b1010;
  localparam logic [3:0] SNS_TYPE = 4'b0011;

  localparam logic [1:0] SREG_TEMP = 2'd0;
  localparam logic [1:0] SREG_LIM  = 2'd1;
  localparam logic [1:0] SREG_CFG  = 2'd2;
endpackage

// File: rtl/i2c_deglitch.sv
module i2c_deglitch #(
  parameter int N        = 2,
  parameter int FILT_CYC = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  localparam int CW = $clog2(FILT_CYC + 1);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic          s1_q, s2_q, lvl_q;
    logic [CW-1:0] run_q;
    logic          lvl_d;
    logic [CW-1:0] run_d;

    always_comb begin
      lvl_d = lvl_q;
      run_d = '0;
      if (s2_q != lvl_q) begin
        if (run_q == CW'(FILT_CYC - 1)) lvl_d = s2_q;
        else                            run_d = run_q + CW'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q  <= 1'b1;
        s2_q  <= 1'b1;
        lvl_q <= 1'b1;
        run_q <= '0;
      end else begin
        s1_q  <= din[g];
        s2_q  <= s1_q;
        lvl_q <= lvl_d;
        run_q <= run_d;
      end
    end

    assign dout[g] = lvl_q;
  end
endmodule

// File: rtl/spd_store.sv
module spd_store #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd
);
  logic [7:0] cells [2**AW];

  always_ff @(posedge clk) begin
    if (we) cells[wa] <= wd;
  end

  assign rd = cells[ra];
endmodule

// File: rtl/therm_regs.sv
module therm_regs import i2cdual_pkg::*; #(
  parameter int            TW       = 12,
  parameter logic [TW-1:0] CRIT_RST = TW'(1360)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] smp,
  input  logic          smp_vld,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [TW-1:0] wd,
  output logic [15:0]   rd,
  output logic          evt_n
);
  logic [TW-1:0] temp_q, lim_q, temp_d, lim_d;
  logic          en_q, en_d, evt_q, evt_d;

  always_comb begin
    temp_d = smp_vld ? smp : temp_q;
    lim_d  = (we && sel == SREG_LIM) ? wd : lim_q;
    en_d   = (we && sel == SREG_CFG) ? wd[0] : en_q;
    evt_d  = ~(en_q && (temp_q >= lim_q));
    case (sel)
      SREG_TEMP: rd = 16'(temp_q);
      SREG_LIM:  rd = 16'(lim_q);
      SREG_CFG:  rd = {15'd0, en_q};
      default:   rd = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      lim_q  <= CRIT_RST;
      en_q   <= 1'b1;
      evt_q  <= 1'b1;
    end else begin
      temp_q <= temp_d;
      lim_q  <= lim_d;
      en_q   <= en_d;
      evt_q  <= evt_d;
    end
  end

  assign evt_n = evt_q;
endmodule

// File: rtl/dual_id_i2c_slave.sv
module dual_id_i2c_slave import i2cdual_pkg::*; #(
  parameter int                FILT_CYC  = 10,
  parameter int                TOUT_CYC  = 3_000_000,
  parameter int                WBUSY_CYC = 500_000,
  parameter int                TEMP_W    = 12,
  parameter logic [TEMP_W-1:0] CRIT_RST  = TEMP_W'(1360)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic [TEMP_W-1:0] temp_smp_i,
  input  logic              temp_vld_i,
  output logic              sda_oe_o,
  output logic              evt_n_o
);
  localparam int TCW = $clog2(TOUT_CYC + 1);
  localparam int WBW = $clog2(WBUSY_CYC + 1);

  logic [1:0] filt;
  logic       scl_f, sda_f, scl_q, sda_q;
  logic       scl_r, scl_fl, start_c, stop_c;

  i2c_deglitch #(.N(2), .FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(filt));
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  bus_st_e        st, n_st;
  logic [3:0]     cnt, n_cnt;
  logic [7:0]     sh, n_sh, txb, n_txb, hold, n_hold, ptr_m, n_ptr_m;
  logic [1:0]     ptr_s, n_ptr_s;
  logic           is_sns, n_is_sns, rnw, n_rnw, first, n_first;
  logic           hilo, n_hilo, mnack, n_mnack, oe, n_oe, wr_seen, n_wr_seen;
  logic [TCW-1:0] tcnt, n_tcnt;
  logic [WBW-1:0] busy_cnt, n_busy;
  logic           tout_hit, do_load, mem_hit, sns_hit;
  logic [7:0]     ld_byte, mem_rd, mem_wa, mem_wd;
  logic           mem_we, sns_we;
  logic [15:0]    sns_rd;

  spd_store #(.AW(8)) u_mem (
    .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd), .ra(ptr_m), .rd(mem_rd));

  therm_regs #(.TW(TEMP_W), .CRIT_RST(CRIT_RST)) u_th (
    .clk(clk), .rst_n(rst_n), .smp(temp_smp_i), .smp_vld(temp_vld_i),
    .we(sns_we), .sel(ptr_s), .wd(TEMP_W'({hold, sh})), .rd(sns_rd),
    .evt_n(evt_n_o));

  assign scl_r    = scl_f & ~scl_q;
  assign scl_fl   = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;
  assign tout_hit = (st != ST_IDLE) && !scl_f && (tcnt == TCW'(TOUT_CYC - 1));
  assign mem_hit  = (sh[7:4] == MEM_TYPE) && (sh[3:1] == strap_i) && (busy_cnt == '0);
  assign sns_hit  = (sh[7:4] == SNS_TYPE) && (sh[3:1] == strap_i);
  assign ld_byte  = is_sns ? (hilo ? hold : sns_rd[15:8]) : mem_rd;

  always_comb begin
    n_st = st; n_cnt = cnt; n_sh = sh; n_txb = txb; n_hold = hold;
    n_ptr_m = ptr_m; n_ptr_s = ptr_s; n_is_sns = is_sns; n_rnw = rnw;
    n_first = first; n_hilo = hilo; n_mnack = mnack; n_oe = oe;
    n_wr_seen = wr_seen; do_load = 1'b0;
    mem_we = 1'b0; mem_wa = ptr_m; mem_wd = sh; sns_we = 1'b0;
    n_tcnt = (st == ST_IDLE || scl_f || tout_hit) ? '0 : tcnt + TCW'(1);
    n_busy = (busy_cnt != '0) ? busy_cnt - WBW'(1) : '0;
    if ((stop_c || tout_hit) && wr_seen) begin
      n_busy    = WBW'(WBUSY_CYC);
      n_wr_seen = 1'b0;
    end
    if (tout_hit || stop_c) begin
      n_st = ST_IDLE; n_oe = 1'b0;
    end else if (start_c) begin
      n_st = ST_ADDR; n_cnt = '0; n_oe = 1'b0; n_hilo = 1'b0;
    end else begin
      case (st)
        ST_ADDR: begin
          if (scl_r) begin n_sh = {sh[6:0], sda_f}; n_cnt = cnt + 4'd1; end
          if (scl_fl && cnt == 4'd8) begin
            if (mem_hit || sns_hit) begin
              n_is_sns = sns_hit; n_rnw = sh[0]; n_oe = 1'b1; n_st = ST_AACK;
            end else n_st = ST_IDLE;
          end
        end
        ST_AACK: if (scl_fl) begin
          if (rnw) do_load = 1'b1;
          else begin n_oe = 1'b0; n_first = 1'b1; n_cnt = '0; n_st = ST_WR; end
        end
        ST_WR: begin
          if (scl_r) begin n_sh = {sh[6:0], sda_f}; n_cnt = cnt + 4'd1; end
          if (scl_fl && cnt == 4'd8) begin
            n_oe = 1'b1; n_st = ST_WACK; n_first = 1'b0;
            if (first) begin
              if (is_sns) begin n_ptr_s = sh[1:0]; n_hilo = 1'b0; end
              else n_ptr_m = sh;
            end else if (is_sns) begin
              if (!hilo) begin n_hold = sh; n_hilo = 1'b1; end
              else begin sns_we = 1'b1; n_hilo = 1'b0; end
            end else begin
              mem_we    = !(wp_i && !ptr_m[7]);
              n_ptr_m   = ptr_m + 8'd1;
              n_wr_seen = 1'b1;
            end
          end
        end
        ST_WACK: if (scl_fl) begin n_oe = 1'b0; n_cnt = '0; n_st = ST_WR; end
        ST_RD: begin
          if (scl_r) n_cnt = cnt + 4'd1;
          if (scl_fl) begin
            if (cnt == 4'd8) begin n_oe = 1'b0; n_st = ST_RACK; end
            else begin n_oe = ~txb[6]; n_txb = {txb[6:0], 1'b0}; end
          end
        end
        ST_RACK: begin
          if (scl_r) n_mnack = sda_f;
          if (scl_fl) begin
            if (mnack) n_st = ST_IDLE;
            else do_load = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (do_load) begin
      n_txb = ld_byte; n_oe = ~ld_byte[7]; n_cnt = '0; n_st = ST_RD;
      if (is_sns) begin
        if (!hilo) n_hold = sns_rd[7:0];
        n_hilo = ~hilo;
      end else n_ptr_m = ptr_m + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; txb <= '0; hold <= '0;
      ptr_m <= '0; ptr_s <= '0; is_sns <= 1'b0; rnw <= 1'b0; first <= 1'b0;
      hilo <= 1'b0; mnack <= 1'b0; oe <= 1'b0; wr_seen <= 1'b0;
      tcnt <= '0; busy_cnt <= '0; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      st <= n_st; cnt <= n_cnt; sh <= n_sh; txb <= n_txb; hold <= n_hold;
      ptr_m <= n_ptr_m; ptr_s <= n_ptr_s; is_sns <= n_is_sns; rnw <= n_rnw;
      first <= n_first; hilo <= n_hilo; mnack <= n_mnack; oe <= n_oe;
      wr_seen <= n_wr_seen; tcnt <= n_tcnt; busy_cnt <= n_busy;
      scl_q <= scl_f; sda_q <= sda_f;
    end
  end

  assign sda_oe_o = oe;
endmodule

// File: rtl/dual_id_i2c_slave_chk.sv
module dual_id_i2c_slave_chk import i2cdual_pkg::*; #(
  parameter int TOUT_CYC = 16,
  parameter int TCW      = 5,
  parameter int WBW      = 5,
  parameter int TEMP_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe_o,
  input logic              evt_n_o,
  input bus_st_e           st,
  input logic              mem_we,
  input logic              wp_i,
  input logic [7:0]        mem_wa,
  input logic [WBW-1:0]    busy_cnt,
  input logic [TCW-1:0]    tcnt,
  input logic              tout_hit,
  input logic [TEMP_W-1:0] temp_q,
  input logic [TEMP_W-1:0] lim_q,
  input logic              en_q
);
  // R5: a locked lower-half byte never reaches the store
  a_r5_lock_lower: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!wp_i || mem_wa[7]));

  // R6: no store is possible while the write period runs
  a_r6_idle_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy_cnt == '0));

  // R7: the low-time counter stays inside its window
  a_r7_tout_window: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt < TCW'(TOUT_CYC));

  // R7: a timeout leaves SDA released
  a_r7_tout_release: assert property (@(posedge clk) disable iff (!rst_n)
    tout_hit |=> !sda_oe_o);

  // R3: SDA is pulled only in acknowledge or read-data phases
  a_r3_drive_phase: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (st == ST_AACK || st == ST_WACK || st == ST_RD));

  // R11: an asserted alarm has an enabled over-limit cause one cycle earlier
  a_r11_alarm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_n_o |-> $past(en_q && (temp_q >= lim_q)));
endmodule

bind dual_id_i2c_slave dual_id_i2c_slave_chk #(
  .TOUT_CYC(TOUT_CYC), .TCW(TCW), .WBW(WBW), .TEMP_W(TEMP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .evt_n_o(evt_n_o), .st(st),
  .mem_we(mem_we), .wp_i(wp_i), .mem_wa(mem_wa), .busy_cnt(busy_cnt),
  .tcnt(tcnt), .tout_hit(tout_hit), .temp_q(u_th.temp_q),
  .lim_q(u_th.lim_q), .en_q(u_th.en_q)
);

// File: tb/dual_id_i2c_slave_tb.sv
`timescale 1ns/1ps
module dual_id_i2c_slave_tb;
  localparam int FILT = 4;
  localparam int TOUT = 500;
  localparam int WB   = 2000;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] MEMW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] MEMR = {4'b1010, STRAP, 1'b1};
  localparam logic [7:0] SNSW = {4'b0011, STRAP, 1'b0};
  localparam logic [7:0] SNSR = {4'b0011, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n, scl, sda_m, wp, temp_vld, sda_oe, evt_n;
  logic [11:0] temp_smp;
  logic sda;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;
  assign sda = sda_m & ~sda_oe;

  dual_id_i2c_slave #(.FILT_CYC(FILT), .TOUT_CYC(TOUT), .WBUSY_CYC(WB)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .strap_i(STRAP),
    .wp_i(wp), .temp_smp_i(temp_smp), .temp_vld_i(temp_vld),
    .sda_oe_o(sda_oe), .evt_n_o(evt_n));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] mval(input logic [7:0] a);
    return a * 8'd37 + 8'd11;
  endfunction

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic r);
    hw(10); sda_m = b; hw(10); scl = 1'b1; hw(10); r = sda; hw(10); scl = 1'b0;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hw(10); scl = 1'b1; hw(20); sda_m = 1'b0; hw(20); scl = 1'b0;
  endtask

  task automatic bus_stop;
    hw(10); sda_m = 1'b0; hw(10); scl = 1'b1; hw(20); sda_m = 1'b1; hw(20);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic get_byte(input logic last, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, r); v[i] = r; end
    bus_bit(last, r);
  endtask

  task automatic mem_rd1(input logic [7:0] p, output logic [7:0] v);
    logic a;
    bus_start; put_byte(MEMW, a); put_byte(p, a);
    bus_start; put_byte(MEMR, a); get_byte(1'b1, v); bus_stop;
  endtask

  task automatic mem_wr1(input logic [7:0] p, input logic [7:0] d, output logic a);
    logic x;
    bus_start; put_byte(MEMW, x); put_byte(p, x); put_byte(d, a); bus_stop; hw(WB + 50);
  endtask

  task automatic sns_rd16(input logic [7:0] p, output logic [15:0] v);
    logic a;
    bus_start; put_byte(SNSW, a); put_byte(p, a);
    bus_start; put_byte(SNSR, a); get_byte(1'b0, v[15:8]); get_byte(1'b1, v[7:0]);
    bus_stop;
  endtask

  task automatic sns_wr16(input logic [7:0] p, input logic [15:0] v);
    logic a;
    bus_start; put_byte(SNSW, a); put_byte(p, a);
    put_byte(v[15:8], a); put_byte(v[7:0], a); bus_stop;
  endtask

  task automatic set_temp(input logic [11:0] t);
    temp_smp = t; temp_vld = 1'b1; hw(1); temp_vld = 1'b0; hw(4);
  endtask

  initial begin
    logic a;
    logic [7:0] v;
    logic [15:0] w;
    scl = 1'b1; sda_m = 1'b1; wp = 1'b0; temp_vld = 1'b0; temp_smp = '0;
    rst_n = 1'b0;
    hw(5); rst_n = 1'b1; hw(10);
    check("R1 reset sda released", sda_oe, 0);
    check("R11 reset alarm high", evt_n, 1);

    // R1 / R2 address decode
    bus_start; put_byte({4'b1010, 3'b100, 1'b0}, a); bus_stop;
    check("R1 strap mismatch nack", a, 0);
    bus_start; put_byte({4'b1011, STRAP, 1'b0}, a); bus_stop;
    check("R1 wrong type nack", a, 0);
    bus_start; put_byte({4'b0011, 3'b001, 1'b0}, a); bus_stop;
    check("R2 sensor strap mismatch nack", a, 0);
    bus_start; put_byte(SNSW, a); bus_stop;
    check("R2 sensor ack", a, 1);

    // R3 / R4 sweep of 64 bytes across the 255->0 wrap
    bus_start; put_byte(MEMW, a);
    check("R1 memory ack", a, 1);
    put_byte(8'hE0, a);
    for (int i = 0; i < 64; i++) put_byte(mval(8'(8'hE0 + i)), a);
    check("R3 last data byte ack", a, 1);
    bus_stop;

    // R6 busy window: memory silent, sensor answers
    bus_start; put_byte(MEMW, a); bus_stop;
    check("R6 memory nack while busy", a, 0);
    bus_start; put_byte(SNSW, a); bus_stop;
    check("R6 sensor ack while busy", a, 1);
    hw(WB);
    bus_start; put_byte(MEMW, a); bus_stop;
    check("R6 memory ack after busy", a, 1);

    // R4 repeated-start read of the whole sweep
    bus_start; put_byte(MEMW, a); put_byte(8'hE0, a);
    bus_start; put_byte(MEMR, a);
    for (int i = 0; i < 64; i++) begin
      get_byte(i == 63, v);
      check(i == 0 ? "R3 read at pointer" : "R4 sequential wrap read",
            v, mval(8'(8'hE0 + i)));
    end
    bus_stop;

    // R5 write lock on the lower half
    wp = 1'b1;
    mem_wr1(8'h05, 8'hC3, a);
    check("R5 locked write acked", a, 1);
    mem_wr1(8'h90, 8'h77, a);
    wp = 1'b0;
    mem_rd1(8'h05, v);
    check("R5 lower byte unchanged", v, mval(8'h05));
    mem_rd1(8'h90, v);
    check("R5 upper byte written", v, 8'h77);

    // R7 timeout while the slave drives a zero data bit (0x10 holds 0x5B)
    bus_start; put_byte(MEMW, a); put_byte(8'h10, a);
    bus_start; put_byte(MEMR, a);
    hw(20);
    check("R7 sda held by slave", sda, 0);
    hw(TOUT + 100);
    check("R7 sda released after timeout", sda, 1);
    bus_stop;
    bus_start; put_byte(MEMW, a); bus_stop;
    check("R7 bus usable after timeout", a, 1);

    // R8 short SDA low pulse with SCL high is not a start
    hw(20); sda_m = 1'b0; hw(2); sda_m = 1'b1; hw(20); scl = 1'b0;
    put_byte(MEMW, a);
    check("R8 glitch not taken as start", a, 0);
    bus_stop;

    // R9 / R10 / R11 sensor registers
    set_temp(12'h5A3);
    check("R11 alarm at code above reset limit", evt_n, 0);
    sns_rd16(8'd0, w);
    check("R9 temperature word", w, 16'h05A3);
    sns_rd16(8'd1, w);
    check("R10 limit reset value", w, 16'h0550);
    sns_rd16(8'd2, w);
    check("R10 config reset value", w, 16'h0001);
    sns_wr16(8'd1, 16'h05A0);
    sns_rd16(8'd1, w);
    check("R10 limit readback", w, 16'h05A0);
    for (int t = 12'h598; t <= 12'h5A8; t++) begin
      set_temp(12'(t));
      check("R11 alarm vs limit", evt_n, (t >= 12'h5A0) ? 0 : 1);
      if (t % 4 == 0) begin
        sns_rd16(8'd0, w);
        check("R9 refreshed code", w, t);
      end
    end
    sns_wr16(8'd0, 16'h0123);
    sns_rd16(8'd0, w);
    check("R9 write to temperature ignored", w, 16'h05A8);
    sns_wr16(8'd2, 16'h0000);
    check("R11 alarm off when disabled", evt_n, 1);
    sns_rd16(8'd2, w);
    check("R10 config readback", w, 16'h0000);
    sns_wr16(8'd2, 16'h0001);
    check("R11 alarm back when enabled", evt_n, 0);
    sns_wr16(8'd1, 16'h05A9);
    check("R11 alarm clears below limit", evt_n, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule